// File: doc/BRIEF.md
# Host Link Start-Up and Configuration Sequencer

This block is the decoder-side controller of a host link. It owns an SPI slave port and an active-low READY request line. After reset it waits a set number of system clocks. It then pulls READY low to ask the host to read an identification packet. Every complete packet the host shifts in is answered the same way: an identification packet is loaded as the next outgoing word, and READY pulses high for a few clocks before it falls again to mark the end of processing.

Two kinds of host packet change the block's state. A control packet sets or clears the decode enable. A checksum packet switches on the block's own output traffic. A one-clock sync-detected pulse from the channel correlator is accepted only while decoding is enabled. It puts the block into synchronous mode. If output is enabled at that moment, the block loads a status packet and raises a READY request by itself.

Top module: `hic_cfg_seq`

## Requirements
- R1: After reset is released, ready_n stays high and falls on the START_DELAY-th rising clock edge (default 76800). Host packets that complete during this wait change nothing.
- R2: Framing is SPI mode 0 with PKT_W = 32 bits sent MSB first. MOSI is sampled on a rising SCLK while spi_ss_n is low. spi_miso presents the outgoing packet MSB first and advances after each falling SCLK.
- R3: The outgoing identification packet is {8'hA0, PART_ID}, with the 24-bit part ID in bits 23:0. It is loaded at reset and again after every accepted host packet.
- R4: A packet is accepted when spi_ss_n rises after exactly 32 SCLK rises. ready_n goes high on the third rising clock after spi_ss_n rises (two synchroniser stages plus one register). It stays high for PULSE_LEN (4) clocks and then returns low.
- R5: A transfer with any bit count other than 32 is discarded: no READY pulse, no change to the enables, and the outgoing packet is kept.
- R6: A control packet has type 8'hC1 in bits 31:24. It sets decode_en to its bit 0.
- R7: A checksum packet has type 8'hC5 in bits 31:24. It sets output_en.
- R8: sync_det is ignored while decode_en is low. When it is accepted, sync_mode rises on the next clock. Later sync_det pulses have no effect.
- R9: On acceptance with output_en high, the status packet {8'hA5, 23'b0, 1'b1} (bit 0 set = synchronous mode) is loaded and a READY pulse starts. The start waits while spi_ss_n is low or a pulse is in progress. With output_en low, no transfer is started and the outgoing packet is unchanged.
- R10: Reset clears decode_en, output_en and sync_mode, drives ready_n high and restarts the start-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_mosi | input | 1 | SPI data from host |
| spi_ss_n | input | 1 | SPI slave select, active low |
| spi_miso | output | 1 | SPI data to host |
| sync_det | input | 1 | One-clock pulse: sync word recognised |
| ready_n | output | 1 | Active-low request / processing-done line |
| decode_en | output | 1 | Decoding enabled by control packet |
| output_en | output | 1 | Own-initiated output enabled by checksum packet |
| sync_mode | output | 1 | Block is in synchronous mode |

## Verification
Each result has a fixed due cycle. The end of the start-up wait is due on clock edge START_DELAY after reset release, and the bench compares a cycle counter to that value. A packet's READY pulse and enable updates are due on the third edge after spi_ss_n rises. A sync-driven request and sync_mode are due on the first edge after sync_det. All are sampled on falling clock edges, one edge before and at the due edge, and the pulse width is counted edge by edge. Discarded transfers and ignored syncs are checked by watching ready_n stay low over a window longer than the normal response time, and by the enables and the next read-back packet.

// File: rtl/hic_pkg.sv
package hic_pkg;
   localparam int TYPE_W = 8;

   localparam logic [TYPE_W-1:0] T_IDENT  = 8'hA0;
   localparam logic [TYPE_W-1:0] T_STATUS = 8'hA5;
   localparam logic [TYPE_W-1:0] T_CTRL   = 8'hC1;
   localparam logic [TYPE_W-1:0] T_CSUM   = 8'hC5;

   typedef enum logic {
      S_WAIT = 1'b0,
      S_RUN  = 1'b1
   } seq_state_t;
endpackage

// File: rtl/hic_sync.sv
module hic_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hic_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hic_spi_shift.sv
module hic_spi_shift #(
   parameter int PKT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sclk,
   input  logic             mosi,
   input  logic             ss_n,
   input  logic [PKT_W-1:0] tx_word,
   output logic             miso,
   output logic [PKT_W-1:0] rx_word,
   output logic             pkt_done,
   output logic             ss_idle
);
   localparam int CW = $clog2(PKT_W + 2);
   localparam logic [CW-1:0] CNT_FULL = CW'(PKT_W);
   localparam logic [CW-1:0] CNT_OVER = CW'(PKT_W + 1);

   logic ss_s, sclk_s, mosi_s;
   logic ss_d, sclk_d;
   logic sclk_rise, sclk_fall, ss_fall, ss_rise;
   logic [CW-1:0]    bit_cnt;
   logic [PKT_W-1:0] rx_sh, tx_sh;

   hic_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({ss_n, sclk, mosi}),
      .q   ({ss_s, sclk_s, mosi_s})
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ss_d   <= 1'b1;
         sclk_d <= 1'b0;
      end else begin
         ss_d   <= ss_s;
         sclk_d <= sclk_s;
      end
   end

   always_comb begin
      sclk_rise = sclk_s & ~sclk_d & ~ss_s;
      sclk_fall = ~sclk_s & sclk_d & ~ss_s;
      ss_fall   = ~ss_s & ss_d;
      ss_rise   = ss_s & ~ss_d;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_cnt <= '0;
         rx_sh   <= '0;
      end else begin
         if (ss_fall) begin
            bit_cnt <= '0;
         end else if (sclk_rise && bit_cnt != CNT_OVER) begin
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (sclk_rise) rx_sh <= {rx_sh[PKT_W-2:0], mosi_s};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_sh <= '0;
      end else if (ss_s) begin
         tx_sh <= tx_word;
      end else if (sclk_fall) begin
         tx_sh <= {tx_sh[PKT_W-2:0], 1'b0};
      end
   end

   assign miso     = tx_sh[PKT_W-1];
   assign rx_word  = rx_sh;
   assign pkt_done = ss_rise & (bit_cnt == CNT_FULL);
   assign ss_idle  = ss_s & ss_d;

   // R5: the bit counter never runs past its saturation value
   p_cnt_bound_r5 : assert property (@(posedge clk) disable iff (rst)
      bit_cnt <= CNT_OVER);

   // R2: received data only moves while the slave is selected
   p_rx_hold_r2 : assert property (@(posedge clk) disable iff (rst)
      (ss_s && ss_d) |=> $stable(rx_sh));
endmodule

// File: rtl/hic_seq.sv
module hic_seq
   import hic_pkg::*;
#(
   parameter int                         PKT_W       = 32,
   parameter int                         START_DELAY = 76800,
   parameter int                         PULSE_LEN   = 4,
   parameter logic [PKT_W-TYPE_W-1:0]    PART_ID     = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pkt_done,
   input  logic [PKT_W-1:0] rx_word,
   input  logic             ss_idle,
   input  logic             sync_det,
   output logic             ready_n,
   output logic [PKT_W-1:0] tx_word,
   output logic             decode_en,
   output logic             output_en,
   output logic             sync_mode
);
   localparam int DW = $clog2(START_DELAY + 1);
   localparam int PW = $clog2(PULSE_LEN + 1);
   localparam logic [DW-1:0] DELAY_LAST = DW'(START_DELAY - 1);
   localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_LEN - 1);
   localparam logic [PKT_W-1:0] ID_PKT   = {T_IDENT, PART_ID};
   localparam logic [PKT_W-1:0] STAT_PKT = {T_STATUS, {(PKT_W-TYPE_W-1){1'b0}}, 1'b1};

   seq_state_t        st;
   logic [DW-1:0]     dcnt;
   logic [PW-1:0]     hcnt;
   logic              pend;
   logic              running, accept, want, idle, issue;
   logic [TYPE_W-1:0] pkt_type;
   logic              unused_payload;

   always_comb begin
      running  = (st == S_RUN);
      pkt_type = rx_word[PKT_W-1 -: TYPE_W];
      accept   = running & sync_det & decode_en & ~sync_mode;
      want     = pend | (accept & output_en);
      idle     = ss_idle & ~ready_n & ~pkt_done;
      issue    = running & want & idle;
   end

   assign unused_payload = ^rx_word[PKT_W-TYPE_W-1:1];

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= S_WAIT;
         dcnt      <= '0;
         hcnt      <= '0;
         ready_n   <= 1'b1;
         tx_word   <= ID_PKT;
         decode_en <= 1'b0;
         output_en <= 1'b0;
         sync_mode <= 1'b0;
         pend      <= 1'b0;
      end else begin
         case (st)
            S_WAIT: begin
               if (dcnt == DELAY_LAST) begin
                  st      <= S_RUN;
                  ready_n <= 1'b0;
               end else begin
                  dcnt <= dcnt + 1'b1;
               end
            end
            S_RUN: begin
               if (pkt_done) begin
                  if (pkt_type == T_CTRL) decode_en <= rx_word[0];
                  if (pkt_type == T_CSUM) output_en <= 1'b1;
                  tx_word <= ID_PKT;
                  ready_n <= 1'b1;
                  hcnt    <= PULSE_LOAD;
               end else if (issue) begin
                  tx_word <= STAT_PKT;
                  ready_n <= 1'b1;
                  hcnt    <= PULSE_LOAD;
               end else if (ready_n) begin
                  if (hcnt == '0) ready_n <= 1'b0;
                  else            hcnt    <= hcnt - 1'b1;
               end
               if (accept) sync_mode <= 1'b1;
               pend <= want & ~issue;
            end
            default: st <= S_WAIT;
         endcase
      end
   end

   // Independent count of the high time of each request pulse (R4)
   logic [PW:0] chk_hi;
   always_ff @(posedge clk) begin
      if (rst || !running || pkt_done || issue) chk_hi <= '0;
      else if (ready_n)                         chk_hi <= chk_hi + 1'b1;
      else                                      chk_hi <= '0;
   end

   // R1: no request while the start-up wait runs
   p_quiet_wait_r1 : assert property (@(posedge clk) disable iff (rst)
      (st == S_WAIT) |-> ready_n);

   // R4: each processing pulse lasts exactly PULSE_LEN clocks
   p_pulse_len_r4 : assert property (@(posedge clk) disable iff (rst)
      ($fell(ready_n) && chk_hi != '0) |-> (chk_hi == (PW+1)'(PULSE_LEN)));

   // R8: synchronous mode is entered only from an enabled sync pulse
   p_sync_gate_r8 : assert property (@(posedge clk) disable iff (rst)
      $rose(sync_mode) |-> $past(decode_en && sync_det));

   // R9: a status packet is only loaded with output enabled
   p_status_gate_r9 : assert property (@(posedge clk) disable iff (rst)
      (tx_word == STAT_PKT && $past(tx_word) != STAT_PKT) |-> output_en);
endmodule

// File: rtl/hic_cfg_seq.sv
module hic_cfg_seq
   import hic_pkg::*;
#(
   parameter int                      PKT_W       = 32,
   parameter int                      START_DELAY = 76800,
   parameter int                      PULSE_LEN   = 4,
   parameter int                      SYNC_STAGES = 2,
   parameter logic [PKT_W-TYPE_W-1:0] PART_ID     = (PKT_W-TYPE_W)'(24'h3B5E17)
) (
   input  logic clk,
   input  logic rst,
   input  logic spi_sclk,
   input  logic spi_mosi,
   input  logic spi_ss_n,
   output logic spi_miso,
   input  logic sync_det,
   output logic ready_n,
   output logic decode_en,
   output logic output_en,
   output logic sync_mode
);
   generate
      if (PKT_W < TYPE_W + 2) begin : g_bad_width
         $error("hic_cfg_seq: PKT_W too small for type field and payload");
      end
      if (START_DELAY < 1) begin : g_bad_delay
         $error("hic_cfg_seq: START_DELAY must be positive");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("hic_cfg_seq: PULSE_LEN must be positive");
      end
   endgenerate

   logic [PKT_W-1:0] tx_word, rx_word;
   logic             pkt_done, ss_idle;

   hic_spi_shift #(.PKT_W(PKT_W), .SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .sclk     (spi_sclk),
      .mosi     (spi_mosi),
      .ss_n     (spi_ss_n),
      .tx_word  (tx_word),
      .miso     (spi_miso),
      .rx_word  (rx_word),
      .pkt_done (pkt_done),
      .ss_idle  (ss_idle)
   );

   hic_seq #(
      .PKT_W       (PKT_W),
      .START_DELAY (START_DELAY),
      .PULSE_LEN   (PULSE_LEN),
      .PART_ID     (PART_ID)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .pkt_done  (pkt_done),
      .rx_word   (rx_word),
      .ss_idle   (ss_idle),
      .sync_det  (sync_det),
      .ready_n   (ready_n),
      .tx_word   (tx_word),
      .decode_en (decode_en),
      .output_en (output_en),
      .sync_mode (sync_mode)
   );
endmodule

// File: tb/tb_hic_cfg_seq.sv
`timescale 1ns/1ps
module tb_hic_cfg_seq;
   localparam int          D     = 600;
   localparam int          PLEN  = 4;
   localparam int          HALF  = 6;
   localparam logic [23:0] PART  = 24'h5A13C7;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sclk = 1'b0, mosi = 1'b0, ss_n = 1'b1, sync_det = 1'b0;
   logic miso, ready_n, decode_en, output_en, sync_mode;
   int   n_chk = 0, n_fail = 0;
   int   cyc = 0;

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

   hic_cfg_seq #(.START_DELAY(D), .PULSE_LEN(PLEN), .PART_ID(PART)) dut (
      .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_ss_n(ss_n),
      .spi_miso(miso), .sync_det(sync_det), .ready_n(ready_n),
      .decode_en(decode_en), .output_en(output_en), .sync_mode(sync_mode)
   );

   function automatic logic [31:0] id_pkt();
      return {8'hA0, PART};
   endfunction
   function automatic logic [31:0] stat_pkt();
      return {8'hA5, 23'd0, 1'b1};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] r);
      r = '0;
      ss_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         mosi = (i < 32) ? w[31-i] : 1'b0;
         repeat (HALF) @(negedge clk);
         sclk = 1'b1;
         r = {r[30:0], miso};
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      ss_n = 1'b1;
   endtask

   // Called at the falling edge on which SS was raised
   task automatic chk_pulse(input string req);
      bit good;
      repeat (2) @(negedge clk);
      check(ready_n == 1'b0, req, "READY early", 32'(ready_n), 32'd0);
      @(negedge clk);
      check(ready_n == 1'b1, req, "READY rise due", 32'(ready_n), 32'd1);
      good = 1'b1;
      repeat (PLEN - 1) begin
         @(negedge clk);
         if (!ready_n) good = 1'b0;
      end
      @(negedge clk);
      check(good && ready_n == 1'b0, req, "READY pulse width", 32'(good), 32'd1);
   endtask

   task automatic chk_quiet(input string req, input int n);
      bit good = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (ready_n) good = 1'b0;
      end
      check(good, req, "READY stays low", 32'(good), 32'd1);
   endtask

   task automatic pulse_sync();
      sync_det = 1'b1;
      @(negedge clk);
      sync_det = 1'b0;
   endtask

   task automatic chk_flags(input string req, input bit ed, input bit eo, input bit es);
      check({decode_en, output_en, sync_mode} == {ed, eo, es}, req, "enables",
            32'({decode_en, output_en, sync_mode}), 32'({ed, eo, es}));
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [31:0] r, w;
      bit          good;
      bit          ed, eo;
      int          n, kind;
      void'($urandom(32'd4242));

      // ---------- phase A: start-up and gating ----------
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check(ready_n == 1'b1, "R10", "READY after reset", 32'(ready_n), 32'd1);
      chk_flags("R10", 0, 0, 0);
      repeat (D - 1) @(negedge clk);
      check(ready_n == 1'b1, "R1", "READY before delay end", 32'(ready_n), 32'd1);
      @(negedge clk);
      check(ready_n == 1'b0, "R1", "READY at delay end", 32'(ready_n), 32'd0);

      w = {8'h33, 24'($urandom)};
      xfer(w, 32, r);
      check(r == id_pkt(), "R2 R3", "ID read-back", r, id_pkt());
      chk_pulse("R4");
      chk_flags("R3", 0, 0, 0);

      pulse_sync();
      chk_quiet("R8", 10);
      chk_flags("R8", 0, 0, 0);

      xfer({8'hC1, 24'h000001}, 31, r);
      chk_quiet("R5", 12);
      chk_flags("R5", 0, 0, 0);

      xfer({8'hC1, 24'h000001}, 32, r);
      chk_pulse("R6");
      chk_flags("R6", 1, 0, 0);

      pulse_sync();
      check(sync_mode == 1'b1, "R8", "sync_mode next clock", 32'(sync_mode), 32'd1);
      chk_quiet("R9", 12);
      xfer({8'h20, 24'h0}, 32, r);
      check(r == id_pkt(), "R9", "no status without output", r, id_pkt());
      chk_pulse("R9");

      xfer({8'hC5, 24'($urandom)}, 32, r);
      chk_pulse("R7");
      chk_flags("R7", 1, 1, 1);

      // ---------- phase B: reset mid-run and own status transfer ----------
      do_reset();
      check(ready_n == 1'b1, "R10", "READY after rerun reset", 32'(ready_n), 32'd1);
      chk_flags("R10", 0, 0, 0);
      xfer({8'hC1, 24'h000001}, 32, r);
      repeat (6) @(negedge clk);
      check(ready_n == 1'b1 && decode_en == 1'b0, "R1", "packet during wait ignored",
            32'({ready_n, decode_en}), 32'b10);
      good = 1'b0;
      for (int i = 0; i < 2000 && !good; i++) begin
         @(negedge clk);
         if (!ready_n) good = 1'b1;
      end
      check(good && cyc == D, "R1", "wait length after reset", 32'(cyc), 32'(D));

      xfer({8'hC1, 24'h7FFFF1}, 32, r);
      chk_pulse("R6");
      xfer({8'hC5, 24'h0}, 32, r);
      chk_pulse("R7");
      chk_flags("R7", 1, 1, 0);

      pulse_sync();
      check(ready_n == 1'b1 && sync_mode == 1'b1, "R9", "status request due",
            32'({ready_n, sync_mode}), 32'b11);
      good = 1'b1;
      repeat (PLEN - 1) begin
         @(negedge clk);
         if (!ready_n) good = 1'b0;
      end
      @(negedge clk);
      check(good && !ready_n, "R9", "status pulse width", 32'(good), 32'd1);
      xfer({8'h44, 24'h0}, 32, r);
      check(r == stat_pkt(), "R9", "status read-back", r, stat_pkt());
      chk_pulse("R4");

      pulse_sync();
      chk_quiet("R8", 10);
      xfer({8'h45, 24'h0}, 32, r);
      check(r == id_pkt(), "R8", "second sync ignored", r, id_pkt());
      chk_pulse("R4");

      // ---------- phase C: constrained random packets ----------
      ed = 1'b1;
      eo = 1'b1;
      for (int it = 0; it < 24; it++) begin
         kind = int'($urandom % 4);
         case (kind)
            0:       w = {8'hC1, 23'($urandom), 1'($urandom)};
            1:       w = {8'hC5, 24'($urandom)};
            default: w = {8'h10 + 8'($urandom % 64), 24'($urandom)};
         endcase
         n = ($urandom % 3 == 0) ? (($urandom % 2 == 0) ? 30 + int'($urandom % 2) : 33) : 32;
         if ($urandom % 4 == 0) begin
            pulse_sync();
            chk_quiet("R8", 4);
         end
         xfer(w, n, r);
         if (n <= 32)
            check(r == (id_pkt() >> (32 - n)), "R2", "random read-back", r, id_pkt() >> (32 - n));
         if (n == 32) begin
            if (w[31:24] == 8'hC1) ed = w[0];
            if (w[31:24] == 8'hC5) eo = 1'b1;
            chk_pulse("R4");
         end else begin
            chk_quiet("R5", 10);
         end
         chk_flags((n == 32) ? "R6 R7" : "R5", ed, eo, 1'b1);
      end

      report();
   end
endmodule